// File: doc/BRIEF.md
# Quantized Gradient-Histogram Block Descriptor

This unit turns a small grayscale patch into a gradient-orientation descriptor for one block of two-by-two square cells. Pixels enter on a valid/ready stream one cell at a time. The cells arrive in the order top-left, top-right, bottom-left, bottom-right, and each cell is sent in raster order (row 0 from column 0 upward, then row 1, and so on). Each pixel is cut to its four most significant bits and stored in a one-cell buffer. Once a cell is complete, a two-stage pipeline walks it once. It forms central-difference gradients, a Manhattan magnitude and a 3-bit orientation bin, and adds the magnitude into that cell's 8-bin voting table.

After the fourth cell, the unit registers the total vote of the block. It then emits 32 descriptor elements on an output valid/ready stream. Each element is one table entry divided by the block total, as a 3-bit fraction with a step of 1/16, so the largest value is 7/16. The unit accepts no input while it processes a cell or emits a descriptor. The output holds its element steady under back-pressure.

Top module: `hogq_block_desc`

## Requirements
- R1: A pixel is taken on a rising edge where in_valid and in_ready are both high. in_ready is high only while a cell is filling. It drops the cycle after the 64th pixel of a cell is taken and stays low until that cell has been processed, or until the descriptor has been emitted in the case of the fourth cell. in_ready and out_valid are never high together.
- R2: Only bits [7:4] of each pixel affect the result. The quantized pixel value is q = pix >> 4.
- R3: With x as the column and y as the row, counted downward, gx = q(x+1,y) - q(x-1,y) and gy = q(x,y+1) - q(x,y-1). A neighbour outside the cell is replaced by the cell's own pixel at the clamped coordinate.
- R4: The vote of a pixel is |gx| + |gy|.
- R5: The bin of a pixel is 4*(gy<0) + 2*(gx<0) + (|gx|>|gy|). The vote goes to that bin of the current cell's table.
- R6: With h as a table entry and S as the sum of all 32 entries, the element is min(7, floor(16*h/S)). When S = 0 the element is 0.
- R7: Each block yields exactly 32 elements. They come in cell order, with bins 0..7 inside each cell, and out_last is high on the 32nd element only.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged on the next cycle.
- R9: All voting tables return to zero after the last element of a block is taken, so a block does not depend on earlier blocks.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on in_pix |
| in_ready | output | 1 | Unit can take a pixel this cycle |
| in_pix | input | 8 | Grayscale pixel |
| out_valid | output | 1 | Descriptor element present |
| out_ready | input | 1 | Consumer takes the element this cycle |
| out_data | output | 3 | Element, fraction in units of 1/16 |
| out_last | output | 1 | Marks the 32nd element of a block |

## Verification
The hardest conditions to reach from the ports are the clamped neighbours at the cell edges and the saturation of an element at 7. Both show up only as a bin total across a whole block. The stimulus therefore uses ramps whose edge columns and rows give gradients of a known, different size. It also uses a block whose energy is concentrated in one cell and one bin, and a flat block that gives a total of zero. Table clearing is reached by sending a flat block directly after a busy one. A stalling consumer pattern holds elements while they are checked.

// File: rtl/hogq_pkg.sv
package hogq_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SCAN = 2'd1,
    ST_SUM  = 2'd2,
    ST_EMIT = 2'd3
  } hogq_state_e;

endpackage

// File: rtl/hogq_cell_buf.sv
module hogq_cell_buf #(
  parameter int PIX_W    = 8,
  parameter int Q_W      = 4,
  parameter int CELL_DIM = 8,
  localparam int CELL_PIX = CELL_DIM * CELL_DIM,
  localparam int IDX_W    = $clog2(CELL_PIX),
  localparam int CRD_W    = $clog2(CELL_DIM)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PIX_W-1:0] wr_pix,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [Q_W-1:0]   nb_left,
  output logic [Q_W-1:0]   nb_right,
  output logic [Q_W-1:0]   nb_up,
  output logic [Q_W-1:0]   nb_down
);

  logic [Q_W-1:0] mem [CELL_PIX];
  logic           unused_low_bits;

  assign unused_low_bits = ^wr_pix[PIX_W-Q_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_pix[PIX_W-1 -: Q_W];
  end

  logic [CRD_W-1:0] cx, cy, xl, xr, yu, yd;

  always_comb begin
    cx = rd_idx[CRD_W-1:0];
    cy = rd_idx[IDX_W-1:CRD_W];
    xl = (cx == '0) ? cx : cx - 1'b1;
    xr = (cx == CRD_W'(CELL_DIM-1)) ? cx : cx + 1'b1;
    yu = (cy == '0) ? cy : cy - 1'b1;
    yd = (cy == CRD_W'(CELL_DIM-1)) ? cy : cy + 1'b1;
    nb_left  = mem[{cy, xl}];
    nb_right = mem[{cy, xr}];
    nb_up    = mem[{yu, cx}];
    nb_down  = mem[{yd, cx}];
  end

endmodule

// File: rtl/hogq_grad.sv
module hogq_grad #(
  parameter int Q_W = 4,
  localparam int G_W   = Q_W + 1,
  localparam int M_W   = Q_W + 1,
  localparam int BIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [Q_W-1:0]   nb_left,
  input  logic [Q_W-1:0]   nb_right,
  input  logic [Q_W-1:0]   nb_up,
  input  logic [Q_W-1:0]   nb_down,
  output logic             out_v,
  output logic [M_W-1:0]   mag,
  output logic [BIN_W-1:0] bin
);

  logic signed [G_W-1:0] gx_q, gy_q;
  logic signed [G_W-1:0] gx_d, gy_d;

  always_comb begin
    gx_d = $signed({1'b0, nb_right}) - $signed({1'b0, nb_left});
    gy_d = $signed({1'b0, nb_down})  - $signed({1'b0, nb_up});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      gx_q  <= '0;
      gy_q  <= '0;
    end else begin
      out_v <= in_v;
      gx_q  <= gx_d;
      gy_q  <= gy_d;
    end
  end

  logic [G_W-1:0] ax, ay;

  always_comb begin
    ax  = gx_q[G_W-1] ? G_W'(-gx_q) : G_W'(gx_q);
    ay  = gy_q[G_W-1] ? G_W'(-gy_q) : G_W'(gy_q);
    mag = M_W'(ax) + M_W'(ay);
    bin = {gy_q[G_W-1], gx_q[G_W-1], (ax > ay)};
  end

endmodule

// File: rtl/hogq_vote.sv
module hogq_vote #(
  parameter int N_CELLS = 4,
  parameter int N_BINS  = 8,
  parameter int M_W     = 5,
  parameter int ACC_W   = 11,
  localparam int CELL_W = $clog2(N_CELLS),
  localparam int BIN_W  = $clog2(N_BINS),
  localparam int SUM_W  = ACC_W + CELL_W + BIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic [CELL_W-1:0] acc_cell,
  input  logic [BIN_W-1:0]  acc_bin,
  input  logic [M_W-1:0]    acc_mag,
  input  logic [CELL_W-1:0] rd_cell,
  input  logic [BIN_W-1:0]  rd_bin,
  output logic [ACC_W-1:0]  rd_val,
  output logic [SUM_W-1:0]  sum_all
);

  logic [ACC_W-1:0] tbl [N_CELLS][N_BINS];

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    for (genvar b = 0; b < N_BINS; b++) begin : g_bin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tbl[c][b] <= '0;
        end else if (clr) begin
          tbl[c][b] <= '0;
        end else if (acc_en && acc_cell == CELL_W'(c) && acc_bin == BIN_W'(b)) begin
          tbl[c][b] <= tbl[c][b] + ACC_W'(acc_mag);
        end
      end
    end
  end

  assign rd_val = tbl[rd_cell][rd_bin];

  always_comb begin
    sum_all = '0;
    for (int c = 0; c < N_CELLS; c++) begin
      for (int b = 0; b < N_BINS; b++) begin
        sum_all = sum_all + SUM_W'(tbl[c][b]);
      end
    end
  end

endmodule

// File: rtl/hogq_quant.sv
module hogq_quant #(
  parameter int ACC_W  = 11,
  parameter int SUM_W  = 16,
  parameter int OUT_W  = 3,
  parameter int FRAC_W = 4,
  localparam int MAXQ  = (1 << OUT_W) - 1,
  localparam int CMP_W = SUM_W + FRAC_W + 2
) (
  input  logic [ACC_W-1:0] h,
  input  logic [SUM_W-1:0] s,
  output logic [OUT_W-1:0] q
);

  logic [CMP_W-1:0] h_scaled;
  logic [MAXQ-1:0]  ge;

  assign h_scaled = CMP_W'(h) << FRAC_W;

  for (genvar k = 1; k <= MAXQ; k++) begin : g_step
    assign ge[k-1] = h_scaled >= (CMP_W'(s) * CMP_W'(k));
  end

  always_comb begin
    q = '0;
    if (s != '0) begin
      for (int i = 0; i < MAXQ; i++) q = q + OUT_W'(ge[i]);
    end
  end

endmodule

// File: rtl/hogq_block_desc.sv
module hogq_block_desc
  import hogq_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int Q_W      = 4,
  parameter int CELL_DIM = 8,
  parameter int N_CELLS  = 4,
  parameter int N_BINS   = 8,
  parameter int OUT_W    = 3,
  parameter int FRAC_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);

  localparam int CELL_PIX = CELL_DIM * CELL_DIM;
  localparam int IDX_W    = $clog2(CELL_PIX);
  localparam int SCAN_W   = IDX_W + 1;
  localparam int CELL_W   = $clog2(N_CELLS);
  localparam int BIN_W    = $clog2(N_BINS);
  localparam int ELEM_N   = N_CELLS * N_BINS;
  localparam int ELEM_W   = $clog2(ELEM_N);
  localparam int M_W      = Q_W + 1;
  localparam int ACC_W    = M_W + IDX_W;
  localparam int SUM_W    = ACC_W + CELL_W + BIN_W;

  hogq_state_e       state;
  logic [IDX_W-1:0]  pix_cnt;
  logic [SCAN_W-1:0] scan_cnt;
  logic [CELL_W-1:0] cell_idx;
  logic [ELEM_W-1:0] elem_cnt;
  logic [SUM_W-1:0]  sum_q;

  logic in_hs, out_hs, issue, elem_end, clr_tbl;

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_EMIT);
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;
  assign issue     = (state == ST_SCAN) && (scan_cnt < SCAN_W'(CELL_PIX));
  assign elem_end  = (elem_cnt == ELEM_W'(ELEM_N-1));
  assign out_last  = out_valid && elem_end;
  assign clr_tbl   = out_hs && elem_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      pix_cnt  <= '0;
      scan_cnt <= '0;
      cell_idx <= '0;
      elem_cnt <= '0;
      sum_q    <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (in_hs) begin
            if (pix_cnt == IDX_W'(CELL_PIX-1)) begin
              pix_cnt  <= '0;
              scan_cnt <= '0;
              state    <= ST_SCAN;
            end else begin
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
        end
        ST_SCAN: begin
          scan_cnt <= scan_cnt + 1'b1;
          if (scan_cnt == SCAN_W'(CELL_PIX+1)) begin
            if (cell_idx == CELL_W'(N_CELLS-1)) begin
              state <= ST_SUM;
            end else begin
              cell_idx <= cell_idx + 1'b1;
              state    <= ST_FILL;
            end
          end
        end
        ST_SUM: begin
          elem_cnt <= '0;
          state    <= ST_EMIT;
        end
        default: begin
          if (out_hs) begin
            if (elem_end) begin
              elem_cnt <= '0;
              cell_idx <= '0;
              state    <= ST_FILL;
            end else begin
              elem_cnt <= elem_cnt + 1'b1;
            end
          end
        end
      endcase
      if (state == ST_SUM) sum_q <= sum_all;
    end
  end

  logic [Q_W-1:0]   nb_l, nb_r, nb_u, nb_d;
  logic             g_v;
  logic [M_W-1:0]   g_mag;
  logic [BIN_W-1:0] g_bin;
  logic [ACC_W-1:0] rd_val;
  logic [SUM_W-1:0] sum_all;

  hogq_cell_buf #(.PIX_W(PIX_W), .Q_W(Q_W), .CELL_DIM(CELL_DIM)) u_buf (
    .clk      (clk),
    .wr_en    (in_hs),
    .wr_idx   (pix_cnt),
    .wr_pix   (in_pix),
    .rd_idx   (scan_cnt[IDX_W-1:0]),
    .nb_left  (nb_l),
    .nb_right (nb_r),
    .nb_up    (nb_u),
    .nb_down  (nb_d)
  );

  hogq_grad #(.Q_W(Q_W)) u_grad (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_v     (issue),
    .nb_left  (nb_l),
    .nb_right (nb_r),
    .nb_up    (nb_u),
    .nb_down  (nb_d),
    .out_v    (g_v),
    .mag      (g_mag),
    .bin      (g_bin)
  );

  hogq_vote #(.N_CELLS(N_CELLS), .N_BINS(N_BINS), .M_W(M_W), .ACC_W(ACC_W)) u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_tbl),
    .acc_en   (g_v),
    .acc_cell (cell_idx),
    .acc_bin  (g_bin),
    .acc_mag  (g_mag),
    .rd_cell  (elem_cnt[ELEM_W-1:BIN_W]),
    .rd_bin   (elem_cnt[BIN_W-1:0]),
    .rd_val   (rd_val),
    .sum_all  (sum_all)
  );

  hogq_quant #(.ACC_W(ACC_W), .SUM_W(SUM_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_quant (
    .h (rd_val),
    .s (sum_q),
    .q (out_data)
  );

endmodule

// File: rtl/hogq_block_desc_chk.sv
module hogq_block_desc_chk #(
  parameter int OUT_W     = 3,
  parameter int BLOCK_PIX = 256,
  parameter int ELEMS     = 32,
  localparam int PC_W = $clog2(BLOCK_PIX) + 1,
  localparam int EC_W = $clog2(ELEMS) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last
);

  logic [PC_W-1:0] pix_seen;
  logic [EC_W-1:0] elem_seen;
  logic            end_hs;

  assign end_hs = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_seen  <= '0;
      elem_seen <= '0;
    end else begin
      if (end_hs) begin
        pix_seen  <= '0;
        elem_seen <= '0;
      end else begin
        if (in_valid && in_ready) pix_seen <= pix_seen + 1'b1;
        if (out_valid && out_ready) elem_seen <= elem_seen + 1'b1;
      end
    end
  end

  // R1: input and output phases never overlap
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8: a stalled element is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R7: emission starts only after a whole block of pixels
  p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pix_seen == PC_W'(BLOCK_PIX)));

  // R7: the last marker falls on the final element
  p_last_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_hs |-> (elem_seen == EC_W'(ELEMS-1)));

  // R7: no element beyond the final one without the marker
  p_no_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (elem_seen < EC_W'(ELEMS-1)));

endmodule

bind hogq_block_desc hogq_block_desc_chk #(
  .OUT_W     (OUT_W),
  .BLOCK_PIX (CELL_DIM*CELL_DIM*N_CELLS),
  .ELEMS     (N_CELLS*N_BINS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/hogq_block_desc_test.sv
module hogq_block_desc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pix = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [2:0] out_data;
  logic       out_last;

  int tests = 0;
  int fails = 0;

  int blk [256];
  int expv [32];

  always #5 clk = ~clk;

  hogq_block_desc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampc(input int v);
    if (v < 0) return 0;
    if (v > 7) return 7;
    return v;
  endfunction

  function automatic int qpix(input int c, input int y, input int x);
    return (blk[c*64 + clampc(y)*8 + clampc(x)] >> 4) & 15;
  endfunction

  task automatic compute_exp();
    int hist [32];
    int s;
    for (int i = 0; i < 32; i++) hist[i] = 0;
    for (int c = 0; c < 4; c++) begin
      for (int y = 0; y < 8; y++) begin
        for (int x = 0; x < 8; x++) begin
          int gx, gy, ax, ay, b;
          gx = qpix(c, y, x+1) - qpix(c, y, x-1);
          gy = qpix(c, y+1, x) - qpix(c, y-1, x);
          ax = (gx < 0) ? -gx : gx;
          ay = (gy < 0) ? -gy : gy;
          b  = 4*(gy < 0) + 2*(gx < 0) + (ax > ay);
          hist[c*8 + b] += ax + ay;
        end
      end
    end
    s = 0;
    for (int i = 0; i < 32; i++) s += hist[i];
    for (int i = 0; i < 32; i++) begin
      if (s == 0) expv[i] = 0;
      else expv[i] = ((16*hist[i]) / s > 7) ? 7 : (16*hist[i]) / s;
    end
  endtask

  task automatic send_block();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pix   = 8'(blk[i]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (i % 64 == 63) begin
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", int'(in_ready), 0, "in_ready after cell end");
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_block(input string req, input int stall);
    int got = 0;
    int guard = 0;
    int held = 0;
    int hdata = 0;
    while (got < 32 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (held) begin
        check("R8", int'(out_valid), 1, "valid held under stall");
        check("R8", int'(out_data), hdata, "data held under stall");
      end
      out_ready = (stall != 0) ? ((guard % 3) == 0) : 1'b1;
      if (out_valid && out_ready) begin
        check(req, int'(out_data), expv[got], $sformatf("element %0d", got));
        check("R7", int'(out_last), (got == 31) ? 1 : 0, $sformatf("last flag at %0d", got));
        got++;
        held = 0;
      end else begin
        held  = out_valid;
        hdata = int'(out_data);
      end
    end
    check("R7", got, 32, "element count");
    @(negedge clk);
    out_ready = 1'b0;
    check("R1", int'(in_ready), 1, "ready after block");
  endtask

  task automatic run_block(input string req, input int stall);
    compute_exp();
    send_block();
    recv_block(req, stall);
  endtask

  task automatic t_reset();
    check("R10", int'(in_ready), 1, "in_ready after reset");
    check("R10", int'(out_valid), 0, "out_valid after reset");
  endtask

  task automatic t_flat();
    for (int i = 0; i < 256; i++) blk[i] = 8'h80;
    run_block("R6", 0);
  endtask

  task automatic t_hramp();
    for (int i = 0; i < 256; i++) blk[i] = ((i % 8) * 2) << 4;
    run_block("R3", 0);
  endtask

  task automatic t_vramp();
    for (int i = 0; i < 256; i++) blk[i] = (7 - ((i / 8) % 8)) * 32 + (i / 64) * 3;
    run_block("R5", 0);
  endtask

  task automatic t_lowbits();
    for (int i = 0; i < 256; i++) blk[i] = (i * 7 + 3) & 15;
    run_block("R2", 0);
  endtask

  task automatic t_mixed();
    int r = 12345;
    for (int i = 0; i < 256; i++) begin
      r = (r * 1103515245 + 12345) & 32'h7fffffff;
      blk[i] = (r >> 8) & 255;
    end
    run_block("R4", 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 256; i++) blk[i] = (i < 64) ? ((i % 8) * 34) : 0;
    run_block("R6", 0);
  endtask

  task automatic t_stall();
    int r = 777;
    for (int i = 0; i < 256; i++) begin
      r = (r * 69069 + 1) & 32'h7fffffff;
      blk[i] = (r >> 5) & 255;
    end
    run_block("R8", 1);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 256; i++) blk[i] = 8'h40;
    run_block("R9", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_hramp();
    t_vramp();
    t_lowbits();
    t_mixed();
    t_saturate();
    t_stall();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule